// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O peripheral that sits on a simple synchronous register bus. Each cycle the bus presents a register index, a write strobe and write data, and the block answers on a combinational read-data port. The number of I/O lines equals the register width, which is a parameter of 8, 16, 32 or 64 bits.

Software changes the output latch in one of three ways. A write to the level register loads the whole latch. A write to the raise register sets only the lines whose bits are 1. A write to the lower register clears only the lines whose bits are 1. The set and clear writes are atomic, so no read-modify-write is needed. Line direction is held in a single state. Two registers of opposite polarity show that state, so a line can never be input and output at once.

Incoming pin levels pass through a two-stage synchroniser before software can read them. A mirror parameter reverses the mapping between register bits and lines in both directions.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every line is an input (`pin_oe` all 0) and the output latch (`pin_out`) is all 0.
- R2: Reading index 0 (level) returns the pin levels through a two-flop synchroniser. A change on `pin_in` shows in the read data after the second rising clock edge. A 1 means the line is high.
- R3: A write to index 1 (raise) sets each latch bit whose write bit is 1, visible on `pin_out` after the write edge. Bits written 0 keep their value.
- R4: A write to index 2 (lower) clears each latch bit whose write bit is 1. Bits written 0 keep their value.
- R5: A write to index 0 loads the whole output latch from the write data.
- R6: A write to index 3 (drive) sets the direction state: bit 1 makes the line an output. `pin_oe` equals the direction state. Reading index 3 returns the state.
- R7: A write to index 4 (float) sets the direction state to the complement of the write data: bit 1 makes the line an input. Reading index 4 always returns the complement of the index 3 readback.
- R8: Reading index 1 or index 2 returns the current output latch.
- R9: With `MIRROR`=1, line n corresponds to register bit WIDTH-1-n on both write and read. With `MIRROR`=0, line n corresponds to bit n.
- R10: Indices 5 to 7 read as 0. Writes to them change neither the latch nor the direction.
- R11: `pin_out` follows the latch whatever the direction, so a value can be preset before a line is made an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register index |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the presented index (combinational) |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Output latch, one bit per line |
| pin_oe | output | WIDTH | Output enable, one bit per line |

## Verification
A corrupted latch or direction bit shows on `pin_out` or `pin_oe` on the cycle after the write that caused it. It also shows on the read port as soon as index 1 to 4 is presented. A fault in the synchroniser shows only through index 0, two edges after the pin changes. A mirroring fault shows as a single line moving to the wrong position. The bench runs an unmirrored 32-bit instance next to a mirrored 8-bit instance. It compares both with a behavioural model on every clock, so a fault appears within one cycle of the stimulus that reveals it.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

    // Register indices on the bus
    typedef enum logic [2:0] {
        SEL_LEVEL = 3'd0,
        SEL_RAISE = 3'd1,
        SEL_LOWER = 3'd2,
        SEL_DRIVE = 3'd3,
        SEL_FLOAT = 3'd4
    } gpio_sel_e;

    localparam int SEL_BITS = 3;

endpackage

// File: rtl/gpio_bit_order.sv
// Maps between register-bit order and line order; the mapping is its own inverse.
module gpio_bit_order #(
    parameter int WIDTH  = 32,
    parameter bit MIRROR = 1'b0
) (
    input  logic [WIDTH-1:0] in_vec,
    output logic [WIDTH-1:0] out_vec
);
    generate
        if (MIRROR) begin : g_mirror
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign out_vec[i] = in_vec[WIDTH-1-i];
            end
        end else begin : g_straight
            assign out_vec = in_vec;
        end
    endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
// Two-stage synchroniser for the asynchronous pin levels.
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
    import gpio_mmio_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter bit MIRROR = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_BITS-1:0] bus_addr,
    input  logic                bus_wr,
    input  logic [WIDTH-1:0]    bus_wdata,
    output logic [WIDTH-1:0]    bus_rdata,
    input  logic [WIDTH-1:0]    pin_in,
    output logic [WIDTH-1:0]    pin_out,
    output logic [WIDTH-1:0]    pin_oe
);
    localparam int LINES = WIDTH;

    generate
        if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
            $error("gpio_mmio_ctrl: WIDTH must be 8, 16, 32 or 64");
        end
    endgenerate

    // Held in line order
    typedef struct packed {
        logic [LINES-1:0] latch;
        logic [LINES-1:0] dir;
    } gpio_state_t;

    gpio_state_t      st_d, st_q;
    logic [LINES-1:0] wr_line;
    logic [LINES-1:0] rd_line;
    logic [LINES-1:0] lvl_line;
    gpio_sel_e        sel;

    assign sel = gpio_sel_e'(bus_addr);

    gpio_bit_order #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_wr_order (
        .in_vec  (bus_wdata),
        .out_vec (wr_line)
    );

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl_line)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            unique case (sel)
                SEL_LEVEL: st_d.latch = wr_line;
                SEL_RAISE: st_d.latch = st_q.latch | wr_line;
                SEL_LOWER: st_d.latch = st_q.latch & ~wr_line;
                SEL_DRIVE: st_d.dir   = wr_line;
                SEL_FLOAT: st_d.dir   = ~wr_line;
                default:   st_d       = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Readback in line order, then mapped back to register order
    always_comb begin
        unique case (sel)
            SEL_LEVEL: rd_line = lvl_line;
            SEL_RAISE: rd_line = st_q.latch;
            SEL_LOWER: rd_line = st_q.latch;
            SEL_DRIVE: rd_line = st_q.dir;
            SEL_FLOAT: rd_line = ~st_q.dir;
            default:   rd_line = '0;
        endcase
    end

    gpio_bit_order #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_rd_order (
        .in_vec  (rd_line),
        .out_vec (bus_rdata)
    );

    assign pin_out = st_q.latch;
    assign pin_oe  = st_q.dir;

endmodule

// File: rtl/gpio_mmio_ctrl_chk.sv
module gpio_mmio_ctrl_chk #(
    parameter int WIDTH  = 32,
    parameter bit MIRROR = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bus_addr,
    input logic             bus_wr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe
);
    function automatic logic [WIDTH-1:0] swap(input logic [WIDTH-1:0] v);
        logic [WIDTH-1:0] r;
        for (int i = 0; i < WIDTH; i++) begin
            r[i] = MIRROR ? v[WIDTH-1-i] : v[i];
        end
        return r;
    endfunction

    a_r1_reset_idle: assert property (@(negedge clk)
        !rst_n |-> (pin_oe == '0 && pin_out == '0));

    a_r3_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=>
        ((pin_out & $past(swap(bus_wdata))) == $past(swap(bus_wdata))));

    a_r4_lower_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2) |=>
        ((pin_out & $past(swap(bus_wdata))) == '0));

    a_r5_level_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0) |=> (pin_out == $past(swap(bus_wdata))));

    a_r6_drive_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3) |=> (pin_oe == $past(swap(bus_wdata))));

    a_r7_float_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd4) |=> (pin_oe == ~$past(swap(bus_wdata))));

    a_r7_float_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd4) |-> (bus_rdata == ~swap(pin_oe)));

    a_r10_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || bus_addr > 3'd4) |=> ($stable(pin_out) && $stable(pin_oe)));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > 3'd4) |-> (bus_rdata == '0));
endmodule

bind gpio_mmio_ctrl gpio_mmio_ctrl_chk #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_mmio_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_mmio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] pins = '0;

    logic [31:0] rd0, out0, oe0;
    logic [7:0]  rd1, out1, oe1;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;   // 250 MHz

    // Unmirrored 32-bit instance
    gpio_mmio_ctrl #(.WIDTH(32), .MIRROR(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rd0), .pin_in(pins),
        .pin_out(out0), .pin_oe(oe0)
    );

    // Mirrored 8-bit instance (R9)
    gpio_mmio_ctrl #(.WIDTH(8), .MIRROR(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata[7:0]), .bus_rdata(rd1), .pin_in(pins[7:0]),
        .pin_out(out1), .pin_oe(oe1)
    );

    // Behavioural reference model, one slot per instance
    int        cfg_w [2] = '{32, 8};
    bit        cfg_m [2] = '{1'b0, 1'b1};
    logic [63:0] m_lat [2];
    logic [63:0] m_dir [2];
    logic [63:0] pin_hist [2][$];

    function automatic logic [63:0] msk(int w);
        return (64'h1 << w) - 64'h1;
    endfunction

    function automatic logic [63:0] remap(logic [63:0] v, int w, bit mir);
        logic [63:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = mir ? v[w-1-i] : v[i];
        return r;
    endfunction

    function automatic logic [63:0] seen_level(int k);
        // level visible two edges after sampling
        if (pin_hist[k].size() < 2) return '0;
        return pin_hist[k][0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_lat[k] = '0;
                m_dir[k] = '0;
                pin_hist[k].delete();
            end else begin
                logic [63:0] wl;
                wl = remap({32'b0, wdata} & msk(cfg_w[k]), cfg_w[k], cfg_m[k]);
                if (wr) begin
                    case (addr)
                        3'd0: m_lat[k] = wl;
                        3'd1: m_lat[k] = m_lat[k] | wl;
                        3'd2: m_lat[k] = m_lat[k] & ~wl;
                        3'd3: m_dir[k] = wl;
                        3'd4: m_dir[k] = ~wl & msk(cfg_w[k]);
                        default: ;
                    endcase
                end
                pin_hist[k].push_back({32'b0, pins} & msk(cfg_w[k]));
                while (pin_hist[k].size() > 2) void'(pin_hist[k].pop_front());
            end
        end
    end

    function automatic logic [63:0] exp_rd(int k);
        case (addr)
            3'd0: return remap(seen_level(k), cfg_w[k], cfg_m[k]);
            3'd1, 3'd2: return remap(m_lat[k], cfg_w[k], cfg_m[k]);
            3'd3: return remap(m_dir[k], cfg_w[k], cfg_m[k]);
            3'd4: return remap(~m_dir[k] & msk(cfg_w[k]), cfg_w[k], cfg_m[k]);
            default: return '0;
        endcase
    endfunction

    task automatic check(string what, int k, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s u%0d %s: actual %h expected %h", cur_req, k, what, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        check("pin_out", 0, {32'b0, out0}, m_lat[0]);
        check("pin_oe",  0, {32'b0, oe0},  m_dir[0]);
        check("rdata",   0, {32'b0, rd0},  exp_rd(0));
        check("pin_out", 1, {56'b0, out1}, m_lat[1]);
        check("pin_oe",  1, {56'b0, oe1},  m_dir[1]);
        check("rdata",   1, {56'b0, rd1},  exp_rd(1));
    end

    task automatic put(logic [2:0] a, logic [31:0] d);
        @(posedge clk); #1;
        addr = a; wr = 1'b1; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic look(logic [2:0] a, int n);
        @(posedge clk); #1;
        addr = a; wr = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog expired: actual %0d cycles expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        look(3'd3, 2);
        look(3'd1, 2);

        // R5 and R11: load latch while all lines are inputs
        cur_req = "R5";
        put(3'd0, 32'hA5A5_3C0F);
        cur_req = "R11";
        look(3'd1, 2);

        // R3: raise bits, others unchanged
        cur_req = "R3";
        put(3'd1, 32'h0000_F0F0);
        look(3'd1, 1);

        // R4: lower bits, others unchanged
        cur_req = "R4";
        put(3'd2, 32'h0F00_000F);
        cur_req = "R8";
        look(3'd2, 1);
        look(3'd1, 1);

        // R6 / R7: direction through both polarities
        cur_req = "R6";
        put(3'd3, 32'hFFFF_0000);
        look(3'd3, 1);
        cur_req = "R7";
        look(3'd4, 1);
        put(3'd4, 32'h00FF_00FF);
        look(3'd3, 1);
        look(3'd4, 1);

        // R2: synchronised level readback with changing pins
        cur_req = "R2";
        look(3'd0, 1);
        @(posedge clk); #1 pins = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        #1 pins = 32'h1234_5678;
        @(posedge clk); #1 pins = 32'h8000_0001;
        repeat (4) @(posedge clk);

        // R10: unmapped indices
        cur_req = "R10";
        put(3'd5, 32'hFFFF_FFFF);
        put(3'd6, 32'hFFFF_FFFF);
        put(3'd7, 32'hFFFF_FFFF);
        look(3'd6, 1);
        look(3'd1, 1);

        // R9: single-line writes land on the mirrored line in u1
        cur_req = "R9";
        put(3'd0, 32'h0);
        put(3'd1, 32'h0000_0001);
        look(3'd1, 1);
        put(3'd3, 32'h0000_0003);
        look(3'd4, 1);

        // Mixed traffic, each op tagged by its requirement
        begin
            logic [31:0] lfsr = 32'h1ACE_B00C;
            for (int n = 0; n < 400; n++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                case (lfsr[2:0])
                    3'd0: cur_req = "R5";
                    3'd1: cur_req = "R3";
                    3'd2: cur_req = "R4";
                    3'd3: cur_req = "R6";
                    3'd4: cur_req = "R7";
                    default: cur_req = "R10";
                endcase
                @(posedge clk); #1;
                addr  = lfsr[2:0];
                wr    = lfsr[5];
                wdata = {lfsr[15:0], lfsr[31:16]} ^ lfsr;
                pins  = lfsr ^ 32'h5A5A_5A5A;
            end
            @(posedge clk); #1 wr = 1'b0;
            repeat (3) @(posedge clk);
        end

        @(negedge clk);
        finish_run();
    end
endmodule